// File: doc/BRIEF.md
# Conditional Data-Processing Execute Stage

This block is the arithmetic and logic step of a 32-bit processor's data-processing path. Each valid cycle it takes an instruction word, the first operand read from the register file and the second operand already produced by the barrel shifter, together with the shifter's carry. It also takes the current N, Z, C and V flags. It decides whether the instruction's condition holds, runs one of sixteen operations and reports the result, the destination register, whether the register file should be written, the next flag values, whether the instruction is undefined and whether the status register must be reloaded from its saved copy.

Results are registered and appear one clock after the inputs. Register storage, the shifter and the saved-status copy live outside the block. When a flag-setting instruction targets the program counter, the block does not touch the flags. Instead it raises a restore request, so that the surrounding core can reload the status register.

Top module: `dpx_exec_stage`

## Requirements
- R1: Field layout: instr[31:28] is the condition, instr[24:21] the opcode, instr[20] the set-flags bit S and instr[15:12] the destination index. Flags are packed {N,Z,C,V} in bits 3..0. Conditions 0..7 pass on, in turn: Z, not Z, C, not C, N, not N, V and not V. Condition 14 always passes.
- R2: Conditions 8..13 pass on, in turn: (C and not Z), (not C or Z), N==V, N!=V, (not Z and N==V) and (Z or N!=V).
- R3: Condition 15 never executes. One cycle later undef_o is 1, wr_en_o is 0 and the flags are unchanged.
- R4: When the condition fails, wr_en_o and restore_o are 0 and flags_o equals the input flags.
- R5: ADD (4), ADC (5) and CMN (11) add. C is the unsigned carry out of bit 31 and V is the signed overflow. ADC adds the C flag as carry-in.
- R6: SUB (2), RSB (3), SBC (6), RSC (7) and CMP (10) subtract. RSB and RSC compute operand minus Rn. C is 1 when no borrow occurs and V is the signed overflow. SBC and RSC subtract an extra 1 when C is 0.
- R7: AND (0), EOR (1), TST (8), TEQ (9), ORR (12), MOV (13), BIC (14) and MVN (15) are logical. With S set they take N from result bit 31, Z from a zero result and C from the shifter carry, and they keep V. With S clear, no flag changes.
- R8: Opcodes 8..11 never write a register and update the flags whenever the condition passes, whatever the S bit.
- R9: A passing non-compare instruction with S=1 and destination 15 raises restore_o, keeps the flags and still writes the result.
- R10: The outputs register one cycle after in_valid_i. With in_valid_i low, valid_o, wr_en_o, undef_o and restore_o are 0 and flags_o follows the input flags. In reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Inputs hold an instruction this cycle |
| instr_i | input | 32 | Instruction word |
| rn_i | input | 32 | First operand (Rn value) |
| opnd_i | input | 32 | Shifter operand |
| shc_i | input | 1 | Shifter carry out |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| valid_o | output | 1 | Registered outputs hold a result |
| res_o | output | 32 | Operation result |
| rd_o | output | 4 | Destination register index |
| wr_en_o | output | 1 | Register file write enable |
| flags_o | output | 4 | Next flags {N,Z,C,V} |
| undef_o | output | 1 | Undefined-instruction indication |
| restore_o | output | 1 | Request to reload status from the saved copy |

## Verification
A wrong condition decision shows up on the very next cycle. A false pass raises wr_en_o or changes flags_o where both should stay quiet, and a false fail holds them back. A carry or overflow fault in the shared adder appears as a single wrong bit in flags_o one cycle after the instruction, so the bench compares all four flags on every operation. It sweeps every condition against all sixteen flag patterns. A mis-steered restore or compare decode shows as a wrong wr_en_o, restore_o or a flag nibble that differs from the input in that same output cycle.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  localparam int COND_HI = 31;
  localparam int COND_LO = 28;
  localparam int OPC_HI  = 24;
  localparam int OPC_LO  = 21;
  localparam int SBIT    = 20;
  localparam int RD_HI   = 15;
  localparam int RD_LO   = 12;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic is_compare(input alu_op_e op);
    return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

  function automatic logic is_logical(input alu_op_e op);
    case (op)
      OP_AND, OP_EOR, OP_TST, OP_TEQ, OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dpx_cond_eval.sv
module dpx_cond_eval
  import dpx_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [CW-1:0] cond_i,
  input  flags_t        fl_i,
  output logic          pass_o,
  output logic          never_o
);

  localparam logic [CW-1:0] NEVER_CODE = {CW{1'b1}};

  logic ge_w;
  assign ge_w = (fl_i.n == fl_i.v);

  always_comb begin
    case (cond_i)
      4'd0:    pass_o = fl_i.z;
      4'd1:    pass_o = !fl_i.z;
      4'd2:    pass_o = fl_i.c;
      4'd3:    pass_o = !fl_i.c;
      4'd4:    pass_o = fl_i.n;
      4'd5:    pass_o = !fl_i.n;
      4'd6:    pass_o = fl_i.v;
      4'd7:    pass_o = !fl_i.v;
      4'd8:    pass_o = fl_i.c && !fl_i.z;
      4'd9:    pass_o = !fl_i.c || fl_i.z;
      4'd10:   pass_o = ge_w;
      4'd11:   pass_o = !ge_w;
      4'd12:   pass_o = !fl_i.z && ge_w;
      4'd13:   pass_o = fl_i.z || !ge_w;
      4'd14:   pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end

  assign never_o = (cond_i == NEVER_CODE);

  always_comb begin
    if (never_o) AST_NEVER_BLOCKS : assert (!pass_o); // R3
  end

endmodule

// File: rtl/dpx_alu.sv
module dpx_alu
  import dpx_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] rn_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          shc_i,
  input  flags_t        fl_i,
  output logic [DW-1:0] res_o,
  output flags_t        arith_fl_o,
  output flags_t        logic_fl_o
);

  localparam int MSB = DW - 1;

  // one adder serves every arithmetic opcode: x + y + cin
  function automatic logic [DW:0] add3(input logic [DW-1:0] x,
                                       input logic [DW-1:0] y,
                                       input logic cin);
    return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
  endfunction

  function automatic logic add_ovf(input logic [DW-1:0] x,
                                   input logic [DW-1:0] y,
                                   input logic [DW-1:0] r);
    return ~(x[MSB] ^ y[MSB]) & (x[MSB] ^ r[MSB]);
  endfunction

  logic [DW-1:0] ax, ay, lres;
  logic          acin;
  logic [DW:0]   asum;

  always_comb begin
    ax   = rn_i;
    ay   = opnd_i;
    acin = 1'b0;
    case (op_i)
      OP_SUB, OP_CMP: begin ax = rn_i;   ay = ~opnd_i; acin = 1'b1;   end
      OP_RSB:         begin ax = opnd_i; ay = ~rn_i;   acin = 1'b1;   end
      OP_ADC:         begin ax = rn_i;   ay = opnd_i;  acin = fl_i.c; end
      OP_SBC:         begin ax = rn_i;   ay = ~opnd_i; acin = fl_i.c; end
      OP_RSC:         begin ax = opnd_i; ay = ~rn_i;   acin = fl_i.c; end
      default:        begin ax = rn_i;   ay = opnd_i;  acin = 1'b0;   end
    endcase
  end

  assign asum = add3(ax, ay, acin);

  always_comb begin
    case (op_i)
      OP_AND, OP_TST: lres = rn_i & opnd_i;
      OP_EOR, OP_TEQ: lres = rn_i ^ opnd_i;
      OP_ORR:         lres = rn_i | opnd_i;
      OP_MOV:         lres = opnd_i;
      OP_BIC:         lres = rn_i & ~opnd_i;
      default:        lres = ~opnd_i;
    endcase
  end

  assign res_o = is_logical(op_i) ? lres : asum[DW-1:0];

  assign arith_fl_o.n = asum[MSB];
  assign arith_fl_o.z = (asum[DW-1:0] == '0);
  assign arith_fl_o.c = asum[DW];
  assign arith_fl_o.v = add_ovf(ax, ay, asum[DW-1:0]);

  assign logic_fl_o.n = lres[MSB];
  assign logic_fl_o.z = (lres == '0);
  assign logic_fl_o.c = shc_i;
  assign logic_fl_o.v = fl_i.v;

endmodule

// File: rtl/dpx_exec_stage.sv
module dpx_exec_stage
  import dpx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int IW   = 32,
  parameter int RI_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid_i,
  input  logic [IW-1:0]   instr_i,
  input  logic [DW-1:0]   rn_i,
  input  logic [DW-1:0]   opnd_i,
  input  logic            shc_i,
  input  logic [3:0]      flags_i,
  output logic            valid_o,
  output logic [DW-1:0]   res_o,
  output logic [RI_W-1:0] rd_o,
  output logic            wr_en_o,
  output logic [3:0]      flags_o,
  output logic            undef_o,
  output logic            restore_o
);

  localparam int CW = COND_HI - COND_LO + 1;
  localparam logic [RI_W-1:0] PC_IDX = {RI_W{1'b1}};

  alu_op_e         op_w;
  logic [CW-1:0]   cond_w;
  logic            sbit_w;
  logic [RI_W-1:0] rd_w;
  flags_t          fl_in;
  logic            unused_bits;

  assign cond_w = instr_i[COND_HI:COND_LO];
  assign op_w   = alu_op_e'(instr_i[OPC_HI:OPC_LO]);
  assign sbit_w = instr_i[SBIT];
  assign rd_w   = instr_i[RD_LO+RI_W-1:RD_LO];
  assign fl_in  = flags_t'(flags_i);
  assign unused_bits = ^{instr_i[27:25], instr_i[19:16], instr_i[11:0]};

  // events brought out for the checks
  logic   cond_pass, cond_never, cmp_op, logic_op;
  logic   want_restore, take_flags, take_write;
  flags_t afl, lfl, next_fl;
  logic [DW-1:0] alu_res;

  dpx_cond_eval #(.CW(CW)) u_cond (
    .cond_i (cond_w),
    .fl_i   (fl_in),
    .pass_o (cond_pass),
    .never_o(cond_never)
  );

  dpx_alu #(.DW(DW)) u_alu (
    .op_i      (op_w),
    .rn_i      (rn_i),
    .opnd_i    (opnd_i),
    .shc_i     (shc_i),
    .fl_i      (fl_in),
    .res_o     (alu_res),
    .arith_fl_o(afl),
    .logic_fl_o(lfl)
  );

  assign cmp_op       = is_compare(op_w);
  assign logic_op     = is_logical(op_w);
  assign want_restore = in_valid_i && cond_pass && sbit_w && !cmp_op && (rd_w == PC_IDX);
  assign take_write   = in_valid_i && cond_pass && !cmp_op;
  assign take_flags   = in_valid_i && cond_pass && (cmp_op || sbit_w) && !want_restore;

  always_comb begin
    next_fl = fl_in;
    if (take_flags) next_fl = logic_op ? lfl : afl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      res_o     <= '0;
      rd_o      <= '0;
      wr_en_o   <= 1'b0;
      flags_o   <= '0;
      undef_o   <= 1'b0;
      restore_o <= 1'b0;
    end else begin
      valid_o   <= in_valid_i;
      res_o     <= alu_res;
      rd_o      <= rd_w;
      wr_en_o   <= take_write;
      flags_o   <= next_fl;
      undef_o   <= in_valid_i && cond_never;
      restore_o <= want_restore;
    end
  end

  AST_NV_UNDEF : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && cond_never) |=> (undef_o && !wr_en_o)); // R3

  AST_FAIL_QUIET : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !cond_pass) |=> (!wr_en_o && !restore_o && flags_o == $past(flags_i))); // R4

  AST_LOGIC_KEEPS_V : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && logic_op) |=> (flags_o[0] == $past(flags_i[0]))); // R7

  AST_CMP_NO_WRITE : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && cmp_op) |=> !wr_en_o); // R8

  AST_RESTORE_HOLDS : assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> (wr_en_o && flags_o == $past(flags_i))); // R9

  AST_IDLE_QUIET : assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> (!valid_o && !wr_en_o && !undef_o && !restore_o)); // R10

endmodule

// File: tb/dpx_exec_stage_bench.sv
`timescale 1ns/1ps
module dpx_exec_stage_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] instr_i = '0, rn_i = '0, opnd_i = '0;
  logic        shc_i = 1'b0;
  logic [3:0]  flags_i = '0;
  logic        valid_o, wr_en_o, undef_o, restore_o;
  logic [31:0] res_o;
  logic [3:0]  rd_o, flags_o;

  int n_run = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dpx_exec_stage u_dpx_exec_stage (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .instr_i(instr_i),
    .rn_i(rn_i), .opnd_i(opnd_i), .shc_i(shc_i), .flags_i(flags_i),
    .valid_o(valid_o), .res_o(res_o), .rd_o(rd_o), .wr_en_o(wr_en_o),
    .flags_o(flags_o), .undef_o(undef_o), .restore_o(restore_o)
  );

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] o,
                                     input logic s, input logic [3:0] rd);
    return {c, 3'b000, o, s, 4'h1, rd, 12'h000};
  endfunction

  // stimulus: instr, rn, operand, shifter carry, flags
  localparam int NV = 14;
  localparam logic [100:0] VEC [NV] = '{
    {mk(4'hE, 4'd4,  1'b1, 4'd2), 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 4'h0},
    {mk(4'hE, 4'd4,  1'b1, 4'd3), 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 4'h0},
    {mk(4'hE, 4'd5,  1'b1, 4'd3), 32'h0000_0001, 32'h0000_0001, 1'b0, 4'h2},
    {mk(4'hE, 4'd11, 1'b0, 4'd0), 32'h8000_0000, 32'h8000_0000, 1'b0, 4'h0},
    {mk(4'hE, 4'd2,  1'b1, 4'd4), 32'h0000_0000, 32'h0000_0001, 1'b0, 4'h0},
    {mk(4'hE, 4'd2,  1'b1, 4'd4), 32'h8000_0000, 32'h0000_0001, 1'b0, 4'h0},
    {mk(4'hE, 4'd3,  1'b1, 4'd5), 32'h0000_0003, 32'h0000_000A, 1'b0, 4'h0},
    {mk(4'hE, 4'd6,  1'b1, 4'd5), 32'h0000_0005, 32'h0000_0003, 1'b0, 4'h0},
    {mk(4'hE, 4'd7,  1'b1, 4'd6), 32'h0000_0004, 32'h0000_0004, 1'b0, 4'h2},
    {mk(4'hE, 4'd10, 1'b1, 4'd7), 32'h0000_0005, 32'h0000_0005, 1'b0, 4'h0},
    {mk(4'hE, 4'd0,  1'b1, 4'd1), 32'hF0F0_0000, 32'h8000_0000, 1'b1, 4'h1},
    {mk(4'hE, 4'd14, 1'b1, 4'd1), 32'h0000_00FF, 32'h0000_00FF, 1'b0, 4'h3},
    {mk(4'hE, 4'd15, 1'b0, 4'd1), 32'h0000_0000, 32'h0000_0000, 1'b1, 4'h5},
    {mk(4'hE, 4'd9,  1'b0, 4'd8), 32'h1234_5678, 32'h1234_5678, 1'b1, 4'h1}
  };

  // condition model: base test picked by the upper three bits, bit 0 inverts
  function automatic logic m_cond(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v, b;
    {n, z, cy, v} = f;
    case (c[3:1])
      3'd0: b = z;
      3'd1: b = cy;
      3'd2: b = n;
      3'd3: b = v;
      3'd4: b = cy & ~z;
      3'd5: b = ~(n ^ v);
      3'd6: b = ~z & ~(n ^ v);
      default: b = ~c[0];
    endcase
    return (c == 4'hE) ? 1'b1 : (c == 4'hF) ? 1'b0 : (b ^ c[0]);
  endfunction

  // wide signed/unsigned arithmetic model
  task automatic model(input logic [31:0] ins, input logic [31:0] rn, input logic [31:0] op,
                       input logic sc, input logic [3:0] f,
                       output logic [31:0] er, output logic ew, output logic [3:0] ef,
                       output logic erst, output logic eund);
    logic [3:0] o;
    logic s, p, cmp, lg, cy;
    longint ua, ub, ur, sa, sb, sr;
    logic [31:0] r;
    logic [3:0] nf;
    o = ins[24:21]; s = ins[20]; cy = f[1];
    p = m_cond(ins[31:28], f);
    cmp = (o >= 4'd8 && o <= 4'd11);
    lg = (o inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15});
    ua = longint'(rn); ub = longint'(op);
    sa = longint'(signed'(rn)); sb = longint'(signed'(op));
    ur = 0; sr = 0; r = 0;
    case (o)
      4'd0, 4'd8:  r = rn & op;
      4'd1, 4'd9:  r = rn ^ op;
      4'd12:       r = rn | op;
      4'd13:       r = op;
      4'd14:       r = rn & ~op;
      4'd15:       r = ~op;
      4'd4, 4'd11: begin ur = ua + ub;      sr = sa + sb; end
      4'd5:        begin ur = ua + ub + longint'(cy); sr = sa + sb + longint'(cy); end
      4'd2, 4'd10: begin ur = ua - ub;      sr = sa - sb; end
      4'd6:        begin ur = ua - ub - longint'(!cy); sr = sa - sb - longint'(!cy); end
      4'd3:        begin ur = ub - ua;      sr = sb - sa; end
      default:     begin ur = ub - ua - longint'(!cy); sr = sb - sa - longint'(!cy); end
    endcase
    if (!lg) r = ur[31:0];
    if (lg) nf = {r[31], r == 0, sc, f[0]};
    else begin
      nf[3] = r[31];
      nf[2] = (r == 0);
      if (o inside {4'd4, 4'd5, 4'd11}) nf[1] = (ur > 64'sh0000_0000_FFFF_FFFF);
      else nf[1] = (ur >= 0);
      nf[0] = (sr > 64'sh7FFF_FFFF) || (sr < -64'sh8000_0000);
    end
    eund = (ins[31:28] == 4'hF);
    erst = p && s && !cmp && (ins[15:12] == 4'hF);
    ew   = p && !cmp;
    ef   = (p && (s || cmp) && !erst) ? nf : f;
    er   = r;
  endtask

  task automatic chk(input string what, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [31:0] ins);
    logic [3:0] o;
    o = ins[24:21];
    if (ins[31:28] == 4'hF) return "R3";
    if (ins[20] && ins[15:12] == 4'hF && !(o >= 4'd8 && o <= 4'd11)) return "R9";
    if (o >= 4'd8 && o <= 4'd11) return "R8";
    if (o inside {4'd4, 4'd5}) return "R5";
    if (o inside {4'd2, 4'd3, 4'd6, 4'd7}) return "R6";
    return "R7";
  endfunction

  task automatic run_one(input logic [31:0] ins, input logic [31:0] rn, input logic [31:0] op,
                         input logic sc, input logic [3:0] f, input string tag);
    logic [31:0] er; logic ew, erst, eund; logic [3:0] ef;
    model(ins, rn, op, sc, f, er, ew, ef, erst, eund);
    @(negedge clk);
    in_valid_i = 1'b1; instr_i = ins; rn_i = rn; opnd_i = op; shc_i = sc; flags_i = f;
    @(negedge clk);
    chk("valid",   "R10", 32'(valid_o), 32'd1);
    chk("wr_en",   tag, 32'(wr_en_o), 32'(ew));
    chk("flags",   tag, 32'(flags_o), 32'(ef));
    chk("restore", tag, 32'(restore_o), 32'(erst));
    chk("undef",   tag, 32'(undef_o), 32'(eund));
    chk("rd",      tag, 32'(rd_o), 32'(ins[15:12]));
    if (ew) chk("result", tag, res_o, er);
    in_valid_i = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    // reset state, R10
    repeat (3) @(negedge clk);
    chk("reset valid", "R10", 32'(valid_o), 32'd0);
    chk("reset wr",    "R10", 32'(wr_en_o), 32'd0);
    chk("reset flags", "R10", 32'(flags_o), 32'd0);
    chk("reset res",   "R10", res_o, 32'd0);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      run_one(VEC[i][100:69], VEC[i][68:37], VEC[i][36:5], VEC[i][4], VEC[i][3:0],
              tag_of(VEC[i][100:69]));
    end

    // every condition code against every flag pattern, R1 and R2
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        run_one(mk(4'(c), 4'd4, 1'b0, 4'd9), 32'd7, 32'd8, 1'b0, 4'(f),
                (c < 8 || c == 14) ? "R1" : (c == 15) ? "R3" : "R2");
      end
    end

    // directed corners with literal expectations
    run_one(mk(4'hE, 4'd4, 1'b1, 4'd2), 32'hFFFF_FFFF, 32'h1, 1'b0, 4'h0, "R5");
    chk("add wrap result", "R5", res_o, 32'h0);
    chk("add wrap flags",  "R5", 32'(flags_o), 32'h6);
    run_one(mk(4'hE, 4'd4, 1'b1, 4'd2), 32'h7FFF_FFFF, 32'h1, 1'b0, 4'h0, "R5");
    chk("add ovf flags",   "R5", 32'(flags_o), 32'h9);
    run_one(mk(4'hE, 4'd2, 1'b1, 4'd2), 32'h0, 32'h1, 1'b0, 4'h0, "R6");
    chk("sub borrow flags", "R6", 32'(flags_o), 32'h8);
    run_one(mk(4'hE, 4'd3, 1'b1, 4'd2), 32'd3, 32'd10, 1'b0, 4'h0, "R6");
    chk("rsb result", "R6", res_o, 32'd7);
    chk("rsb flags",  "R6", 32'(flags_o), 32'h2);
    run_one(mk(4'hE, 4'd6, 1'b1, 4'd2), 32'd5, 32'd3, 1'b0, 4'h0, "R6");
    chk("sbc result", "R6", res_o, 32'd1);
    run_one(mk(4'hE, 4'd10, 1'b0, 4'd2), 32'd5, 32'd5, 1'b0, 4'h0, "R8");
    chk("cmp no write", "R8", 32'(wr_en_o), 32'd0);
    chk("cmp flags",    "R8", 32'(flags_o), 32'h6);
    run_one(mk(4'hF, 4'd4, 1'b1, 4'd2), 32'd1, 32'd1, 1'b0, 4'h9, "R3");
    chk("nv undef", "R3", 32'(undef_o), 32'd1);
    chk("nv flags", "R3", 32'(flags_o), 32'h9);
    run_one(mk(4'h0, 4'd4, 1'b1, 4'd2), 32'd1, 32'd1, 1'b0, 4'h1, "R4");
    chk("eq fail write", "R4", 32'(wr_en_o), 32'd0);
    chk("eq fail flags", "R4", 32'(flags_o), 32'h1);
    run_one(mk(4'hE, 4'd13, 1'b1, 4'hF), 32'd0, 32'h0, 1'b1, 4'hA, "R9");
    chk("restore req",   "R9", 32'(restore_o), 32'd1);
    chk("restore flags", "R9", 32'(flags_o), 32'hA);
    chk("restore write", "R9", 32'(wr_en_o), 32'd1);
    run_one(mk(4'hE, 4'd0, 1'b1, 4'd2), 32'hF000_0000, 32'h8000_0000, 1'b1, 4'h1, "R7");
    chk("and flags keep V", "R7", 32'(flags_o), 32'hB);

    // idle cycle, R10
    @(negedge clk);
    flags_i = 4'h5;
    @(negedge clk);
    chk("idle valid", "R10", 32'(valid_o), 32'd0);
    chk("idle flags", "R10", 32'(flags_o), 32'h5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule